// File: doc/BRIEF.md
# Addressed Local-Select Decoder for a Shared Serial Bus

This block sits on the device side of a shared serial bus. While the master holds the select line low, it sends one address byte MSB-first on the data-out line, one bit per serial-clock rising edge. The upper nibble of that byte is the bus address, which the block compares with a 4-bit value strapped on jumpers. The low three bits pick one of eight local strobe outputs. When the master releases the select line, the block drives the chosen strobe low if the bus address matched. The strobe stays low for the whole data phase that follows, until the select line is asserted again.

Some strobes serve fixed roles:
- Local 0 is the chip select of an attached memory card. The serial clock and data-out pass straight through to the card, and the card's serial output is returned to the master.
- Locals 1 and 2 put the card-present and write-protect levels onto the master's serial input. Reading a byte there gives all ones or all zeros.
- Locals 3 and 4 set and clear an indicator latch.
- The remaining locals are general-purpose selects.

All serial inputs are sampled by the device clock. The serial clock must therefore run well below that clock, and every input must be held for at least one clock period.

Top module: `spi_local_sel`

## Requirements
- R1: While select_n is low, each rising edge of sclk shifts mosi into the address register MSB-first. Sclk edges while select_n is high shift nothing.
- R2: The bus address is bits 7:4 of the received byte and is compared with the jumper input. Bit 3 takes no part in the decision.
- R3: At the first clock edge where select_n is seen high after being low, a match drives local_n[bits 2:0] low. All other local_n bits stay high. Example: with jumpers 1001, byte 0x92 drives local_n = 8'hFB. The strobe then holds, whatever sclk and mosi do, until select_n falls.
- R4: On a bus-address mismatch, all local_n bits stay high after release.
- R5: At the first clock edge where a new low level of select_n is seen, all local_n go high and the address register is cleared. Bits from an earlier frame therefore never reach the next decision.
- R6: sclk_out and mosi_out always equal sclk and mosi. While local 0 is active, miso is driven (miso_oe = 1) with card_miso.
- R7: While local 1 is active, miso is driven with card_present (1 = present). While local 2 is active, miso is driven with card_wp (1 = protected).
- R8: While none of locals 0, 1 and 2 is active, miso_oe is 0.
- R9: Selecting local 3 sets led to 1 at the same edge that the strobe falls. Selecting local 4 clears it. Any other selection leaves it unchanged.
- R10: While rst_n is low at a clock edge, local_n goes to 8'hFF, led to 0 and miso_oe to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_id | input | 4 | Jumper-set bus address |
| select_n | input | 1 | Active-low address strobe from the master |
| sclk | input | 1 | Serial clock from the master |
| mosi | input | 1 | Serial data from the master |
| card_miso | input | 1 | Serial output of the attached card |
| card_present | input | 1 | 1 when a card is inserted |
| card_wp | input | 1 | 1 when the card is write protected |
| miso | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Drive enable for miso; 0 means high impedance |
| sclk_out | output | 1 | Serial clock forwarded to the card |
| mosi_out | output | 1 | Serial data forwarded to the card |
| local_n | output | 8 | Active-low local strobes |
| led | output | 1 | Indicator latch state |

## Verification
Each input the bench drives is seen at the next rising clock edge. Strobes and the indicator therefore change at that edge, one register after a select_n transition. The miso path and the forwarded clock and data are combinational and follow their inputs within the same cycle. The bench changes inputs one nanosecond after a rising edge and moves its reference model forward only after the edge that consumes them. It compares every output at each falling edge. The cases covered are:
- partial frames after a full one, which expose a missing clear;
- bytes that differ only in bit 3;
- sclk activity during the data phase.

// File: rtl/spi_sel_pkg.sv
// Package: shared types of the local-select decoder.
// Assumes: nothing beyond IEEE 1800-2017.
package spi_sel_pkg;

    // Per-clock events derived from the sampled serial inputs.
    typedef struct packed {
        logic start;   // select_n seen falling: new frame
        logic shift;   // sclk rising while selected
        logic done;    // select_n seen rising: address phase over
    } spi_evt_t;

endpackage

// File: rtl/addr_shifter.sv
// Module: addr_shifter
// Samples select_n and sclk in the device clock domain and derives frame
// events from them. Collects the address byte MSB-first from mosi.
// Assumes: the serial inputs are synchronous to clk, or slow and already
// synchronised, and each level is held for at least one clk period.
module addr_shifter
    import spi_sel_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              select_n,
    input  logic              sclk,
    input  logic              mosi,
    output spi_evt_t          evt,
    output logic [ADDR_W-1:0] addr_q
);

    logic sel_d;
    logic sclk_d;

    // Keep last-cycle levels so edges can be seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_d  <= 1'b1;
            sclk_d <= 1'b0;
        end else begin
            sel_d  <= select_n;
            sclk_d <= sclk;
        end
    end

    // Turn level changes into one-cycle frame events.
    always_comb begin
        evt.start = sel_d & ~select_n;
        evt.done  = ~sel_d & select_n;
        evt.shift = ~select_n & sclk & ~sclk_d;
    end

    // Clear on a new frame, else shift one bit per selected sclk rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (evt.start) begin
            addr_q <= '0;
        end else if (evt.shift) begin
            addr_q <= {addr_q[ADDR_W-2:0], mosi};
        end
    end

    // R1: with select released nothing can enter the register
    a_r1_no_shift_idle: assert property (@(posedge clk) disable iff (!rst_n)
        select_n |=> $stable(addr_q));

    // R5: a new frame starts from an empty register
    a_r5_clear_reg: assert property (@(posedge clk) disable iff (!rst_n)
        evt.start |=> (addr_q == '0));

endmodule

// File: rtl/local_decoder.sv
// Module: local_decoder
// Compares the bus field of the received byte with the jumper value at the
// end of the address phase. Registers one active-low strobe per local
// address and holds it until the next frame starts.
// Assumes: the bus field occupies the top BUS_W bits and the local field the
// low LOC_W bits; any bits between them are ignored.
module local_decoder
    import spi_sel_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BUS_W  = 4,
    parameter int LOC_W  = 3,
    localparam int NLOC  = 1 << LOC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  spi_evt_t          evt,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [BUS_W-1:0]  bus_id,
    output logic [NLOC-1:0]   local_n,
    output logic              act_valid,
    output logic [LOC_W-1:0]  act_idx
);

    logic [BUS_W-1:0] bus_field;
    logic             match;

    // Pick out the fields and decide whether this device is addressed.
    always_comb begin
        bus_field = addr_q[ADDR_W-1 -: BUS_W];
        act_idx   = addr_q[LOC_W-1:0];
        match     = (bus_field == bus_id);
        act_valid = evt.done & match;
    end

    for (genvar i = 0; i < NLOC; i++) begin : g_loc
        // Strobe i: cleared at frame start, set by a matching release.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                local_n[i] <= 1'b1;
            end else if (evt.start) begin
                local_n[i] <= 1'b1;
            end else if (evt.done) begin
                local_n[i] <= !(match && (act_idx == LOC_W'(i)));
            end
        end
    end

    // R3: at most one strobe low at any time
    a_r3_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~local_n));

    // R3: strobes only change at frame boundaries
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt.start && !evt.done) |=> $stable(local_n));

    // R4: a foreign bus address leaves every strobe inactive
    a_r4_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (evt.done && (addr_q[ADDR_W-1 -: BUS_W] != bus_id)) |=> (&local_n));

    // R5: a new frame deselects everything
    a_r5_clear_out: assert property (@(posedge clk) disable iff (!rst_n)
        evt.start |=> (&local_n));

endmodule

// File: rtl/ind_latch.sv
// Module: ind_latch
// Set/clear indicator driven by selection of two local addresses.
// Assumes: act_valid pulses for one cycle at each matching release.
module ind_latch #(
    parameter int LOC_W   = 3,
    parameter int SET_IDX = 3,
    parameter int CLR_IDX = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_valid,
    input  logic [LOC_W-1:0] act_idx,
    output logic             led
);

    // Set or clear on a matching selection, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            led <= 1'b0;
        end else if (act_valid && act_idx == LOC_W'(SET_IDX)) begin
            led <= 1'b1;
        end else if (act_valid && act_idx == LOC_W'(CLR_IDX)) begin
            led <= 1'b0;
        end
    end

    // R9: selections other than set/clear leave the latch alone
    a_r9_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_valid) |=> $stable(led));

endmodule

// File: rtl/miso_mux.sv
// Module: miso_mux
// Chooses what the device returns to the master: the card's serial output,
// a status level repeated for every bit, or nothing (output enable low).
// Assumes: at most one strobe is active.
module miso_mux #(
    parameter int NLOC     = 8,
    parameter int CARD_IDX = 0,
    parameter int PRES_IDX = 1,
    parameter int WP_IDX   = 2
) (
    input  logic [NLOC-1:0] local_n,
    input  logic            card_miso,
    input  logic            card_present,
    input  logic            card_wp,
    output logic            miso,
    output logic            miso_oe
);

    // Priority select of the returned data and its enable.
    always_comb begin
        miso    = 1'b0;
        miso_oe = 1'b0;
        if (!local_n[CARD_IDX]) begin
            miso    = card_miso;
            miso_oe = 1'b1;
        end else if (!local_n[PRES_IDX]) begin
            miso    = card_present;
            miso_oe = 1'b1;
        end else if (!local_n[WP_IDX]) begin
            miso    = card_wp;
            miso_oe = 1'b1;
        end
    end

endmodule

// File: rtl/spi_local_sel.sv
// Module: spi_local_sel (top)
// Device-side select decoder: collects the address byte, matches the bus
// field against jumpers, drives one local strobe during the data phase,
// returns status or card data on miso and keeps an indicator latch.
// Assumes: serial inputs sampled by clk as described in addr_shifter.
module spi_local_sel
    import spi_sel_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int BUS_W    = 4,
    parameter int LOC_W    = 3,
    parameter int CARD_IDX = 0,
    parameter int PRES_IDX = 1,
    parameter int WP_IDX   = 2,
    parameter int SET_IDX  = 3,
    parameter int CLR_IDX  = 4,
    localparam int NLOC    = 1 << LOC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BUS_W-1:0] bus_id,
    input  logic             select_n,
    input  logic             sclk,
    input  logic             mosi,
    input  logic             card_miso,
    input  logic             card_present,
    input  logic             card_wp,
    output logic             miso,
    output logic             miso_oe,
    output logic             sclk_out,
    output logic             mosi_out,
    output logic [NLOC-1:0]  local_n,
    output logic             led
);

    spi_evt_t          evt;
    logic [ADDR_W-1:0] addr_q;
    logic              act_valid;
    logic [LOC_W-1:0]  act_idx;

    // Forward clock and data to the attached card unchanged.
    assign sclk_out = sclk;
    assign mosi_out = mosi;

    addr_shifter #(.ADDR_W(ADDR_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .select_n (select_n),
        .sclk     (sclk),
        .mosi     (mosi),
        .evt      (evt),
        .addr_q   (addr_q)
    );

    local_decoder #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .LOC_W(LOC_W)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (evt),
        .addr_q    (addr_q),
        .bus_id    (bus_id),
        .local_n   (local_n),
        .act_valid (act_valid),
        .act_idx   (act_idx)
    );

    ind_latch #(.LOC_W(LOC_W), .SET_IDX(SET_IDX), .CLR_IDX(CLR_IDX)) u_led (
        .clk       (clk),
        .rst_n     (rst_n),
        .act_valid (act_valid),
        .act_idx   (act_idx),
        .led       (led)
    );

    miso_mux #(.NLOC(NLOC), .CARD_IDX(CARD_IDX), .PRES_IDX(PRES_IDX),
               .WP_IDX(WP_IDX)) u_miso (
        .local_n      (local_n),
        .card_miso    (card_miso),
        .card_present (card_present),
        .card_wp      (card_wp),
        .miso         (miso),
        .miso_oe      (miso_oe)
    );

    // R9: the set strobe falling comes with the latch on
    a_r9_set: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(local_n[SET_IDX]) |-> led);

    // R9: the clear strobe falling comes with the latch off
    a_r9_clr: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(local_n[CLR_IDX]) |-> !led);

    // R8: no read-back strobe, no drive onto miso
    a_r8_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        (local_n[CARD_IDX] && local_n[PRES_IDX] && local_n[WP_IDX]) |-> !miso_oe);

    // R6: the card's chip select always comes with miso driven
    a_r6_card_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (!local_n[CARD_IDX]) |-> (miso_oe && miso == card_miso));

endmodule

// File: tb/sim_spi_local_sel.sv
`timescale 1ns/1ps
module sim_spi_local_sel;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_id = 4'b1001;
    logic       select_n = 1'b1;
    logic       sclk = 1'b0;
    logic       mosi = 1'b0;
    logic       card_miso = 1'b0;
    logic       card_present = 1'b0;
    logic       card_wp = 1'b0;
    logic       miso, miso_oe, sclk_out, mosi_out, led;
    logic [7:0] local_n;

    int vectors = 0;
    int fails = 0;
    bit checking = 1'b0;

    // Reference state: selected local (-1 none), latch, model shift register.
    int         exp_loc = -1;
    bit         exp_led = 1'b0;
    logic [7:0] mdl_sr = 8'h00;

    spi_local_sel u0 (
        .clk(clk), .rst_n(rst_n), .bus_id(bus_id), .select_n(select_n),
        .sclk(sclk), .mosi(mosi), .card_miso(card_miso),
        .card_present(card_present), .card_wp(card_wp), .miso(miso),
        .miso_oe(miso_oe), .sclk_out(sclk_out), .mosi_out(mosi_out),
        .local_n(local_n), .led(led)
    );

    always #2 clk = ~clk;   // 250 MHz

    task automatic check(input bit ok, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", what, act, exp, $time);
        end
    endtask

    // Compare all outputs against the model on every falling edge.
    always @(negedge clk) begin
        if (checking) begin
            logic [7:0] eln;
            logic       eoe, emiso;
            eln = 8'hFF;
            if (exp_loc >= 0) eln[exp_loc] = 1'b0;
            eoe = (exp_loc >= 0 && exp_loc <= 2);
            emiso = (exp_loc == 0) ? card_miso :
                    (exp_loc == 1) ? card_present :
                    (exp_loc == 2) ? card_wp : 1'b0;
            check(local_n === eln, "R1/R2/R3/R4/R5/R10 local_n", local_n, eln);
            check(led === exp_led, "R9/R10 led", {7'b0, led}, {7'b0, exp_led});
            check(miso_oe === eoe, "R6/R7/R8/R10 miso_oe", {7'b0, miso_oe}, {7'b0, eoe});
            if (eoe)
                check(miso === emiso, "R6/R7 miso", {7'b0, miso}, {7'b0, emiso});
            check(sclk_out === sclk && mosi_out === mosi, "R6 passthrough",
                  {6'b0, sclk_out, mosi_out}, {6'b0, sclk, mosi});
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Frame: assert select, shift nbits MSB-first from b, release.
    task automatic frame(input logic [7:0] b, input int nbits);
        select_n = 1'b0;
        tick();
        exp_loc = -1;          // R5: new assertion deselects
        mdl_sr = 8'h00;
        for (int i = 7; i > 7 - nbits; i--) begin
            mosi = b[i];
            sclk = 1'b0;
            tick();
            sclk = 1'b1;
            tick();
            mdl_sr = {mdl_sr[6:0], b[i]};   // R1
            sclk = 1'b0;
            tick();
        end
        select_n = 1'b1;
        tick();
        if (mdl_sr[7:4] == bus_id) begin   // R2
            exp_loc = int'(mdl_sr[2:0]);   // R3
            if (exp_loc == 3) exp_led = 1'b1;   // R9
            if (exp_loc == 4) exp_led = 1'b0;
        end else begin
            exp_loc = -1;                  // R4
        end
    endtask

    // Data phase: toggle sclk/mosi with select released and cards changing.
    task automatic data_phase(input int n);
        for (int i = 0; i < n; i++) begin
            sclk = ~sclk;
            mosi = i[1];
            card_miso = i[0];
            tick();
        end
        sclk = 1'b0;
        tick();
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) tick();
        checking = 1'b1;           // R10: reset values under reset
        tick();
        rst_n = 1'b1;
        tick();

        // R3: jumpers 1001, byte 0x92 -> local 2 (write-protect readback, R7)
        card_wp = 1'b1;
        frame(8'h92, 8);
        data_phase(16);
        card_wp = 1'b0;
        data_phase(4);

        // R7: present readback gives ones then zeros
        card_present = 1'b1;
        frame(8'h91, 8);
        data_phase(16);
        card_present = 1'b0;
        data_phase(4);

        // R6: card chip select with card data returned
        frame(8'h90, 8);
        data_phase(20);

        // R2: bit 3 ignored
        frame(8'h9B, 8);           // local 3, sets led (R9)
        data_phase(6);
        frame(8'h95, 8);           // other local, led kept; R8 no drive
        data_phase(6);
        frame(8'h9C, 8);           // local 4 clears led
        data_phase(6);

        // R4: mismatch leaves everything inactive
        frame(8'h12, 8);
        data_phase(6);
        frame(8'h1B, 8);           // mismatch carrying local 3: led untouched
        data_phase(4);

        // R5: full frame then empty frame; clear makes it read 0x00
        bus_id = 4'b0000;
        frame(8'hFF, 8);
        frame(8'h00, 0);
        data_phase(6);
        // R5: partial frame of 4 bits lands in the low nibble
        frame(8'hA0, 4);           // shifted 1010 -> byte 0x0A -> local 2
        data_phase(6);

        // R1: other jumper values and patterns
        for (int j = 0; j < 16; j++) begin
            bus_id = 4'(j);
            frame({4'(j), 1'b0, 3'(j)}, 8);
            data_phase(3);
            frame({4'(j ^ 5), 1'b1, 3'(7 - j)}, 8);
            data_phase(3);
        end

        // R10: reset in the middle of a selection
        bus_id = 4'b0110;
        frame(8'h63, 8);
        rst_n = 1'b0;
        tick();
        exp_loc = -1;
        exp_led = 1'b0;
        tick();
        rst_n = 1'b1;
        tick();
        data_phase(4);

        checking = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule